// File: doc/BRIEF.md
# Receive FIFO Inactivity Timeout Detector

This block raises a sticky per-channel timeout flag when a receive FIFO holds data and no new entry has arrived for a programmed number of time units. One wide free-running timer, advanced by a slow tick, serves every channel. Each channel picks one bit of that timer as its unit of time and counts the transitions of that bit while its FIFO is not empty. A write into the FIFO restarts the count. When the count reaches the channel's 4-bit compare value, the flag is set and stays set until software clears it.

The unit for base select `b` is 2^b ticks, and the compare value `L` (2 to 15) sets the number of units. The timer may step across a unit boundary just after data arrives, so the delay lies between `(L-1)*2^b+1` and `L*2^b` ticks. The flag is cleared by a write-one to the status bit, by a write-one to the channel's interrupt enable, or by any change of that enable.

Top module: `rxto_detect`

## Requirements
- R1: A single timer of `TMR_W` bits (default 19) advances by one on each clock where `tmr_tick` is 1 and holds otherwise. While `tmr_tick` is 0 no channel makes progress towards a timeout.
- R2: The unit of time is timer bit `cfg_base` (4-bit field per channel at bits `[4*ch+3:4*ch]`, 0 to 15). Every transition of that bit counts. With `tmr_tick` held at 1, let E0 be the clock edge that registers a FIFO write with `fifo_nempty` high, and let L be `cfg_limit`. The flag is 0 after edge E0+(L-1)*2^b and 1 after edge E0+L*2^b.
- R3: A compare value of 0 or 1 never raises the flag.
- R4: A FIFO write (`fifo_wr` = 1) restarts the unit count at zero. Writes spaced closer than the timeout keep the flag at 0.
- R5: Counting happens only while `fifo_nempty` is 1. An empty FIFO resets the count, and after data returns the full L units are needed again.
- R6: Detection is active only while the channel's `irq_en` bit is 1.
- R7: The flag is sticky. Further FIFO writes and timer progress do not clear it.
- R8: A 1 on `stat_wr1` clears the flag at the next clock edge. A clear takes priority over a set in the same cycle.
- R9: A 1 on `irq_en_wr1`, or any change of `irq_en` in either direction, clears the flag at the next clock edge.
- R10: Synchronous reset (`rst` = 1) forces every flag to 0.
- R11: Changing `cfg_base` while a count is in progress produces no spurious count. The new bit is counted only from its own next transition.
- R12: Channels are independent. One channel's inputs never change another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_tick | input | 1 | Advance strobe for the shared timer |
| cfg_base | input | 4*NCH | Per-channel timer bit select |
| cfg_limit | input | 4*NCH | Per-channel compare value in units |
| irq_en | input | NCH | Per-channel timeout interrupt enable |
| irq_en_wr1 | input | NCH | Pulse: a 1 was written to the enable |
| stat_wr1 | input | NCH | Pulse: a 1 was written to the timeout status bit |
| fifo_wr | input | NCH | Pulse: an entry was pushed into the receive FIFO |
| fifo_nempty | input | NCH | Receive FIFO holds at least one entry |
| rx_timeout | output | NCH | Sticky timeout flag per channel |

## Verification
The bench builds the block with two channels and the default 19-bit timer. This keeps one channel idle while the other times out, which exposes any cross-channel coupling. Base selects 0 and 3 give exact cycle windows for the earliest and latest expiry. Base 15, whose bit does not toggle within the run, shows that a mid-count change of select adds no phantom units.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    localparam int TMR_W   = 19;
    localparam int BASE_W  = 4;
    localparam int LIM_W   = 4;
    localparam int MIN_LIM = 2;

    typedef logic [LIM_W-1:0]  lim_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef struct packed {
        base_t base;
        lim_t  limit;
    } chan_cfg_t;

    typedef struct packed {
        logic en;
        logic en_wr1;
        logic stat_wr1;
    } chan_ctl_t;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_COUNT   = 2'd1,
        CH_EXPIRED = 2'd2
    } ch_phase_e;

    function automatic logic lim_ok(lim_t l);
        return l >= lim_t'(MIN_LIM);
    endfunction

endpackage

// File: rtl/rxto_timer.sv
module rxto_timer #(
    parameter int TMR_W = rxto_pkg::TMR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [TMR_W-1:0] flips
);
    logic [TMR_W-1:0] timer_q;
    logic [TMR_W-1:0] timer_inc;

    always_comb timer_inc = timer_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            flips   <= '0;
        end else if (tick) begin
            timer_q <= timer_inc;
            flips   <= timer_q ^ timer_inc;
        end else begin
            flips   <= '0;
        end
    end

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (timer_q == $past(timer_q) + 1'b1));
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(timer_q) && flips == '0));
    assert_lsb_flip_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> flips[0]);
endmodule

// File: rtl/rxto_tap.sv
module rxto_tap #(
    parameter int TMR_W  = rxto_pkg::TMR_W,
    parameter int BASE_W = rxto_pkg::BASE_W
) (
    input  logic [TMR_W-1:0]  flips,
    input  logic [BASE_W-1:0] base,
    output logic              unit_edge
);
    localparam int IDX_W = (TMR_W > 1) ? $clog2(TMR_W) : 1;
    localparam int SEL_W = (IDX_W > BASE_W) ? IDX_W : BASE_W;

    logic [SEL_W-1:0] sel;

    always_comb begin
        sel = SEL_W'(base);
        if (sel < SEL_W'(TMR_W))
            unit_edge = flips[sel[IDX_W-1:0]];
        else
            unit_edge = 1'b0;
    end
endmodule

// File: rtl/rxto_chan.sv
module rxto_chan
    import rxto_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      unit_edge,
    input  chan_cfg_t cfg,
    input  chan_ctl_t ctl,
    input  logic      fifo_wr,
    input  logic      fifo_nempty,
    output logic      flag
);
    lim_t      cnt_q, cnt_d;
    logic      en_q;
    logic      clr_evt;
    logic      armed;
    logic      can_step;
    logic      hit;
    logic      flag_d;
    ch_phase_e phase;

    always_comb begin
        clr_evt  = ctl.stat_wr1 | ctl.en_wr1 | (ctl.en ^ en_q);
        armed    = ctl.en & fifo_nempty & lim_ok(cfg.limit);
        can_step = armed & ~fifo_wr & unit_edge & ~flag & (cnt_q < cfg.limit);
        hit      = can_step & (lim_t'(cnt_q + 1'b1) == cfg.limit);

        if (!armed || fifo_wr)
            cnt_d = '0;
        else if (can_step)
            cnt_d = lim_t'(cnt_q + 1'b1);
        else
            cnt_d = cnt_q;

        if (clr_evt)
            flag_d = 1'b0;
        else if (hit)
            flag_d = 1'b1;
        else
            flag_d = flag;

        if (flag)
            phase = CH_EXPIRED;
        else if (armed)
            phase = CH_COUNT;
        else
            phase = CH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
            flag  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            en_q  <= ctl.en;
            flag  <= flag_d;
        end
    end

    assert_rise_at_limit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (cnt_q == $past(cfg.limit)));
    assert_bad_limit_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> lim_ok($past(cfg.limit)));
    assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |=> (cnt_q == '0));
    assert_empty_R5: assert property (@(posedge clk) disable iff (rst)
        !fifo_nempty |=> (cnt_q == '0));
    assert_need_enable_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(ctl.en && fifo_nempty && !fifo_wr));
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !ctl.stat_wr1 && !ctl.en_wr1 && (ctl.en == en_q)) |=> flag);
    assert_stat_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.stat_wr1 |=> !flag);
    assert_en_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl.en_wr1 || (ctl.en != en_q)) |=> !flag);
    assert_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == CH_IDLE) |=> (cnt_q == '0));
endmodule

// File: rtl/rxto_detect.sv
module rxto_detect
    import rxto_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_tick,
    input  logic [4*NCH-1:0]  cfg_base,
    input  logic [4*NCH-1:0]  cfg_limit,
    input  logic [NCH-1:0]    irq_en,
    input  logic [NCH-1:0]    irq_en_wr1,
    input  logic [NCH-1:0]    stat_wr1,
    input  logic [NCH-1:0]    fifo_wr,
    input  logic [NCH-1:0]    fifo_nempty,
    output logic [NCH-1:0]    rx_timeout
);
    logic [TMR_W-1:0] flips;

    rxto_timer #(.TMR_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tmr_tick),
        .flips (flips)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        chan_cfg_t cfg;
        chan_ctl_t ctl;
        logic      unit_edge;

        always_comb begin
            cfg.base     = cfg_base[ch*BASE_W +: BASE_W];
            cfg.limit    = cfg_limit[ch*LIM_W +: LIM_W];
            ctl.en       = irq_en[ch];
            ctl.en_wr1   = irq_en_wr1[ch];
            ctl.stat_wr1 = stat_wr1[ch];
        end

        rxto_tap #(.TMR_W(TMR_W), .BASE_W(BASE_W)) u_tap (
            .flips     (flips),
            .base      (cfg.base),
            .unit_edge (unit_edge)
        );

        rxto_chan u_chan (
            .clk         (clk),
            .rst         (rst),
            .unit_edge   (unit_edge),
            .cfg         (cfg),
            .ctl         (ctl),
            .fifo_wr     (fifo_wr[ch]),
            .fifo_nempty (fifo_nempty[ch]),
            .flag        (rx_timeout[ch])
        );
    end

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (rx_timeout == '0));
endmodule

// File: tb/rxto_detect_test.sv
module rxto_detect_test;
    localparam int NCH = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tmr_tick = 1'b0;
    logic [4*NCH-1:0] cfg_base = '0;
    logic [4*NCH-1:0] cfg_limit = '0;
    logic [NCH-1:0]   irq_en = '0;
    logic [NCH-1:0]   irq_en_wr1 = '0;
    logic [NCH-1:0]   stat_wr1 = '0;
    logic [NCH-1:0]   fifo_wr = '0;
    logic [NCH-1:0]   fifo_nempty = '0;
    logic [NCH-1:0]   rx_timeout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rxto_detect #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .tmr_tick(tmr_tick),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .irq_en(irq_en), .irq_en_wr1(irq_en_wr1), .stat_wr1(stat_wr1),
        .fifo_wr(fifo_wr), .fifo_nempty(fifo_nempty), .rx_timeout(rx_timeout)
    );

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(string req, int ch, logic exp);
        checks++;
        if (rx_timeout[ch] !== exp) begin
            fails++;
            $display("FAIL %s ch%0d: rx_timeout=%0b expected %0b", req, ch, rx_timeout[ch], exp);
        end
    endtask

    task automatic idle_all();
        irq_en = '0; fifo_nempty = '0; fifo_wr = '0; stat_wr1 = '0; irq_en_wr1 = '0;
        tmr_tick = 1'b1;
        step(2);
    endtask

    task automatic setup(int ch, int b, int l);
        cfg_base[ch*4 +: 4]  = 4'(b);
        cfg_limit[ch*4 +: 4] = 4'(l);
        irq_en[ch] = 1'b1;
        step(1);
    endtask

    task automatic push(int ch);
        fifo_wr[ch] = 1'b1;
        fifo_nempty[ch] = 1'b1;
        step(1);
        fifo_wr[ch] = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset ch0", 0, 1'b0);
        check("R10 reset ch1", 1, 1'b0);
    endtask

    task automatic t_window(int b, int l);
        idle_all();
        setup(0, b, l);
        push(0);
        step((l - 1) * (1 << b));
        check("R2 before window", 0, 1'b0);
        step((1 << b));
        check("R2 at window end", 0, 1'b1);
    endtask

    task automatic t_restart();
        idle_all();
        setup(0, 0, 5);
        push(0);
        for (int k = 0; k < 6; k++) begin
            step(2);
            push(0);
        end
        step(3);
        check("R4 writes keep flag low", 0, 1'b0);
        step(2);
        check("R4 timeout after last write", 0, 1'b1);
    endtask

    task automatic t_empty();
        idle_all();
        setup(0, 0, 6);
        push(0);
        step(3);
        fifo_nempty[0] = 1'b0;
        step(2);
        fifo_nempty[0] = 1'b1;
        step(5);
        check("R5 empty reset count", 0, 1'b0);
        step(1);
        check("R5 full count after refill", 0, 1'b1);
        idle_all();
        setup(0, 0, 2);
        step(30);
        check("R5 empty never times out", 0, 1'b0);
    endtask

    task automatic t_disabled();
        idle_all();
        cfg_base[3:0] = 4'd0; cfg_limit[3:0] = 4'd2;
        push(0);
        step(30);
        check("R6 disabled no flag", 0, 1'b0);
    endtask

    task automatic t_bad_limit();
        idle_all();
        setup(0, 0, 1);
        push(0);
        step(30);
        check("R3 limit 1", 0, 1'b0);
        idle_all();
        setup(0, 0, 0);
        push(0);
        step(30);
        check("R3 limit 0", 0, 1'b0);
    endtask

    task automatic t_clear();
        idle_all();
        setup(0, 0, 2);
        push(0);
        step(3);
        check("R7 flag set", 0, 1'b1);
        push(0);
        step(5);
        check("R7 sticky over write", 0, 1'b1);
        stat_wr1[0] = 1'b1;
        step(1);
        stat_wr1[0] = 1'b0;
        check("R8 status write-1 clears", 0, 1'b0);
        push(0);
        step(3);
        check("R8 rearm after clear", 0, 1'b1);
        irq_en_wr1[0] = 1'b1;
        step(1);
        irq_en_wr1[0] = 1'b0;
        check("R9 enable write-1 clears", 0, 1'b0);
        push(0);
        step(3);
        check("R9 rearm", 0, 1'b1);
        irq_en[0] = 1'b0;
        step(1);
        check("R9 enable drop clears", 0, 1'b0);
    endtask

    task automatic t_base_change();
        idle_all();
        setup(0, 0, 3);
        push(0);
        step(1);
        cfg_base[3:0] = 4'd15;
        step(200);
        check("R11 no false count on base change", 0, 1'b0);
    endtask

    task automatic t_tick();
        idle_all();
        setup(0, 0, 2);
        tmr_tick = 1'b0;
        push(0);
        step(20);
        check("R1 halted timer", 0, 1'b0);
        tmr_tick = 1'b1;
        step(3);
        check("R1 resumed timer", 0, 1'b1);
    endtask

    task automatic t_independent();
        idle_all();
        setup(0, 0, 2);
        setup(1, 0, 3);
        fifo_nempty[0] = 1'b0;
        push(1);
        step(4);
        check("R12 ch1 times out", 1, 1'b1);
        check("R12 ch0 unaffected", 0, 1'b0);
        stat_wr1[0] = 1'b1;
        step(1);
        stat_wr1[0] = 1'b0;
        check("R12 ch1 ignores ch0 clear", 1, 1'b1);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_window(0, 4);
        t_window(3, 2);
        t_window(0, 15);
        t_restart();
        t_empty();
        t_disabled();
        t_bad_limit();
        t_clear();
        t_base_change();
        t_tick();
        t_independent();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule